// File: doc/BRIEF.md
# Random Generator Command and Status Front End

This block sits between a host register bus and an external entropy stage. The host drives it by writing 32-bit command words to a control register. The block answers through a one-byte status code and hands over random words through a data register. At the control offset, a bus write reaches the control register and a bus read reaches the data register. The status register is read at offset 0x4.

Bring-up follows a fixed command order. A reset command starts a bounded wait that ends with the reset-acknowledged code. The host then sends release, enable and zeroize, in that order. Zeroize opens a startup window of a configurable number of cycles. When the window closes, the block samples the pass/fail result from the entropy stage. A pass must be acknowledged by the host before normal operation begins. A failure stays latched until the next reset command.

In normal operation each random word is gated by host commands. An enable command arms capture, and one word is latched from the valid/data pair. The status then shows "word available" until the host sends a read-acknowledge. The next word needs a fresh enable.

Top module: `trng_cmd_front`

## Requirements
- R1: After the reset input, the status register reads 0x00 and the data register reads zero.
- R2: Writes go to the control register only at offset 0x0. Reads return the data register at 0x0, the status code at 0x4 in bits 7:0 with the upper bits zero, and zero at any other offset. A write to any other offset has no effect.
- R3: After the reset command 0x00000001, the status reads 0x00 for RESET_CYC-1 cycles. It reads 0xAC from exactly RESET_CYC clock edges after the edge that took the command.
- R4: From the 0xAC state, the block accepts release (0x00000002), then enable (0x80000000), then zeroize (0x80000004), in that order only. A command that arrives out of order is ignored, and the status stays 0xAC.
- R5: Zeroize starts a window of WIN_CYC cycles. During the window the status is 0x00. When the window ends, the status becomes 0x57 if the pass input is high, or 0xFA if it is low.
- R6: Status 0xFA holds against every command except reset.
- R7: Acknowledge-zeroize (0x80000008) after 0x57 enters normal operation, where the status is 0x00 while no word is held. Before 0x57, acknowledge-zeroize is ignored.
- R8: In normal operation, enable arms the block. The first cycle with valid high while armed latches that word. The status then reads 0xED, and the data register returns the latched word.
- R9: While a word is held, further valid words and enable commands leave it unchanged. Read-acknowledge (0x8000000F) drops 0xED. Valid input with no enable since the last acknowledge is not captured.
- R10: Any command word outside the six encodings leaves all state unchanged.
- R11: A reset command is taken in every state. It drops a held word and any arming. It wins over a capture in the same cycle.
- R12: The data register reads zero whenever no word is held, including before startup completes and after a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data (command word) |
| bus_rdata | output | 32 | Read data |
| ent_valid | input | 1 | Entropy stage presents a word |
| ent_data | input | 32 | Random word from the entropy stage |
| st_pass | input | 1 | Startup test result, high for pass |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a capture and a command. An enable written while valid is already high must not capture on that edge. A reset command written on the very edge where an armed block sees valid must leave nothing held. The bench sets ent_valid high and then issues the write task, so both arrive at one edge. It then reads status and data and expects 0x00 and zero. A randomized run of words with random data, gaps and unknown commands is checked against a bench model of the hold state.

// File: rtl/trng_fe_pkg.sv
package trng_fe_pkg;
   localparam int BUS_W = 32;

   localparam logic [BUS_W-1:0] CMD_RESET    = 32'h0000_0001;
   localparam logic [BUS_W-1:0] CMD_RELEASE  = 32'h0000_0002;
   localparam logic [BUS_W-1:0] CMD_ENABLE   = 32'h8000_0000;
   localparam logic [BUS_W-1:0] CMD_ZEROIZE  = 32'h8000_0004;
   localparam logic [BUS_W-1:0] CMD_ACK_ZERO = 32'h8000_0008;
   localparam logic [BUS_W-1:0] CMD_RD_ACK   = 32'h8000_000F;

   localparam logic [7:0] STS_NONE    = 8'h00;
   localparam logic [7:0] STS_RST_ACK = 8'hAC;
   localparam logic [7:0] STS_PASS    = 8'h57;
   localparam logic [7:0] STS_FAIL    = 8'hFA;
   localparam logic [7:0] STS_WORD    = 8'hED;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RST_WAIT, ST_RST_ACK, ST_RELEASED, ST_ENABLED,
      ST_TESTING, ST_PASS, ST_FAIL, ST_RUN
   } fe_state_e;

   typedef struct packed {
      logic reset;
      logic release_rst;
      logic enable;
      logic zeroize;
      logic ack_zero;
      logic rd_ack;
   } fe_cmd_t;
endpackage

// File: rtl/trng_fe_decode.sv
module trng_fe_decode
   import trng_fe_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output fe_cmd_t           cmd
);
   logic hit;

   always_comb begin
      hit             = wr && (addr == '0);
      cmd.reset       = hit && (wdata == CMD_RESET);
      cmd.release_rst = hit && (wdata == CMD_RELEASE);
      cmd.enable      = hit && (wdata == CMD_ENABLE);
      cmd.zeroize     = hit && (wdata == CMD_ZEROIZE);
      cmd.ack_zero    = hit && (wdata == CMD_ACK_ZERO);
      cmd.rd_ack      = hit && (wdata == CMD_RD_ACK);
   end

   always_comb begin
      a_onehot_r10 : assert ($onehot0(cmd));
   end
endmodule

// File: rtl/trng_fe_seq.sv
module trng_fe_seq
   import trng_fe_pkg::*;
#(
   parameter int RESET_CYC = 20000,
   parameter int WIN_CYC   = 1000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  fe_cmd_t    cmd,
   input  logic       st_pass,
   input  logic       hold,
   output fe_state_e  state,
   output logic [7:0] status
);
   localparam int MAX_CYC = (RESET_CYC > WIN_CYC) ? RESET_CYC : WIN_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESET_CYC - 1);
   localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else if (cmd.reset) begin
         state <= ST_RST_WAIT;
         cnt   <= '0;
      end else begin
         case (state)
            ST_RST_WAIT: begin
               if (cnt == RST_LAST) state <= ST_RST_ACK;
               else                 cnt   <= cnt + 1'b1;
            end
            ST_RST_ACK:  if (cmd.release_rst) state <= ST_RELEASED;
            ST_RELEASED: if (cmd.enable)      state <= ST_ENABLED;
            ST_ENABLED: if (cmd.zeroize) begin
               state <= ST_TESTING;
               cnt   <= '0;
            end
            ST_TESTING: begin
               if (cnt == WIN_LAST) state <= st_pass ? ST_PASS : ST_FAIL;
               else                 cnt   <= cnt + 1'b1;
            end
            ST_PASS:     if (cmd.ack_zero)    state <= ST_RUN;
            default:     state <= state;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_RST_ACK, ST_RELEASED, ST_ENABLED: status = STS_RST_ACK;
         ST_PASS: status = STS_PASS;
         ST_FAIL: status = STS_FAIL;
         ST_RUN:  status = hold ? STS_WORD : STS_NONE;
         default: status = STS_NONE;
      endcase
   end

   p_ack_from_wait_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_RST_ACK) |-> $past(state) == ST_RST_WAIT);
   p_window_exit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TESTING && !cmd.reset) |=>
         (state == ST_TESTING || state == ST_PASS || state == ST_FAIL));
   p_fail_latch_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAIL && !cmd.reset) |=> state == ST_FAIL);
   p_pass_wait_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PASS && !cmd.reset && !cmd.ack_zero) |=> state == ST_PASS);
endmodule

// File: rtl/trng_fe_hold.sv
module trng_fe_hold
   import trng_fe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  fe_cmd_t          cmd,
   input  logic             ent_valid,
   input  logic [BUS_W-1:0] ent_data,
   output logic             hold,
   output logic [BUS_W-1:0] word
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         hold  <= 1'b0;
         word  <= '0;
      end else if (cmd.reset || !run) begin
         armed <= 1'b0;
         hold  <= 1'b0;
         word  <= '0;
      end else if (hold) begin
         if (cmd.rd_ack) begin
            hold <= 1'b0;
            word <= '0;
         end
      end else if (armed) begin
         if (ent_valid) begin
            hold  <= 1'b1;
            word  <= ent_data;
            armed <= 1'b0;
         end
      end else if (cmd.enable) begin
         armed <= 1'b1;
      end
   end

   p_no_capture_unarmed_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !hold) |=> !hold);
   p_hold_stable_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !cmd.rd_ack && !cmd.reset && run) |=> (hold && $stable(word)));
   p_reset_drop_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd.reset |=> (!hold && !armed));
   p_zero_empty_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !hold |-> word == '0);
endmodule

// File: rtl/trng_cmd_front.sv
module trng_cmd_front
   import trng_fe_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int RESET_CYC   = 20000,
   parameter int RESET_LIMIT = 40000,
   parameter int WIN_CYC     = 1000000,
   parameter bit RDATA_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ent_valid,
   input  logic [31:0]       ent_data,
   input  logic              st_pass
);
   localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_STS  = ADDR_W'(4);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x4");
   end
   if (RESET_CYC < 1 || RESET_CYC > RESET_LIMIT) begin : g_bad_reset
      $error("RESET_CYC must lie in 1..RESET_LIMIT");
   end
   if (WIN_CYC < 1) begin : g_bad_win
      $error("WIN_CYC must be at least 1");
   end

   fe_cmd_t    cmd;
   fe_state_e  state;
   logic [7:0] status;
   logic       hold;
   logic [31:0] word;
   logic [31:0] rd_mux;

   trng_fe_decode #(.ADDR_W(ADDR_W)) u_decode (
      .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .cmd(cmd)
   );

   trng_fe_seq #(.RESET_CYC(RESET_CYC), .WIN_CYC(WIN_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .st_pass(st_pass),
      .hold(hold), .state(state), .status(status)
   );

   trng_fe_hold u_hold (
      .clk(clk), .rst_n(rst_n), .run(state == ST_RUN), .cmd(cmd),
      .ent_valid(ent_valid), .ent_data(ent_data), .hold(hold), .word(word)
   );

   always_comb begin
      rd_mux = '0;
      if (bus_rd) begin
         if (bus_addr == OFS_DATA)     rd_mux = hold ? word : '0;
         else if (bus_addr == OFS_STS) rd_mux = {24'h0, status};
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bus_rdata <= '0;
         else if (bus_rd) bus_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

   p_hold_in_run_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> state == ST_RUN);
   p_word_status_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> status == STS_WORD);
endmodule

// File: tb/trng_cmd_front_bench.sv
module trng_cmd_front_bench;
   localparam int AW = 4;
   localparam int RC = 6;
   localparam int WC = 12;

   logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, ent_data = '0;
   logic ent_valid = 1'b0, st_pass = 1'b0;
   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   trng_cmd_front #(.ADDR_W(AW), .RESET_CYC(RC), .RESET_LIMIT(100), .WIN_CYC(WC))
      u_trng_cmd_front (
         .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
         .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
         .ent_valid(ent_valid), .ent_data(ent_data), .st_pass(st_pass));

   function automatic logic [31:0] sts(logic [7:0] c);
      return {24'h0, c};
   endfunction

   function automatic logic [31:0] exp_data(bit held, logic [31:0] w);
      return held ? w : 32'h0;
   endfunction

   function automatic logic [31:0] junk_cmd(logic [31:0] r);
      return (r & 32'h7FFF_FFFF) | 32'h10;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic chk_sts(string tag, logic [7:0] c);
      logic [31:0] v;
      rd(4'h4, v);
      chk(tag, v, sts(c));
   endtask

   task automatic chk_dat(string tag, logic [31:0] e);
      logic [31:0] v;
      rd(4'h0, v);
      chk(tag, v, e);
   endtask

   task automatic reset_cmd();
      wr(4'h0, 32'h0000_0001);
      idle(RC - 1);
      chk_sts("R3 before ack", 8'h00);
      idle(1);
      chk_sts("R3 ack", 8'hAC);
   endtask

   task automatic startup(bit pass);
      st_pass = pass;
      wr(4'h0, 32'h0000_0002);
      wr(4'h0, 32'h8000_0000);
      wr(4'h0, 32'h8000_0004);
      chk_sts("R5 window", 8'h00);
      idle(WC - 1);
      chk_sts("R5 window end-1", 8'h00);
      idle(1);
      chk_sts("R5 result", pass ? 8'h57 : 8'hFA);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got %0d cycles expected below 100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] w, v;
      void'($urandom(32'h5EED));
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk_sts("R1 status", 8'h00);
      chk_dat("R1 R12 data", 32'h0);

      wr(4'h0, 32'h0000_0002);
      chk_sts("R4 early release", 8'h00);
      wr(4'h0, 32'h1234_5670);
      chk_sts("R10 unknown idle", 8'h00);

      reset_cmd();
      wr(4'h0, 32'h8000_0000);
      chk_sts("R4 enable before release", 8'hAC);
      wr(4'h8, 32'h0000_0002);
      chk_sts("R2 release at other offset", 8'hAC);
      wr(4'h0, 32'h0000_0002);
      wr(4'h0, 32'h8000_0004);
      chk_sts("R4 zeroize before enable", 8'hAC);
      wr(4'h0, 32'h8000_0008);
      chk_sts("R7 ack zeroize too early", 8'hAC);
      rd(4'h8, v);
      chk("R2 other offset read", v, 32'h0);
      wr(4'h0, 32'h8000_0000);
      wr(4'h0, 32'h8000_0004);
      chk_sts("R5 window", 8'h00);
      idle(WC - 1);
      chk_sts("R5 window end-1", 8'h00);
      idle(1);
      chk_sts("R5 fail", 8'hFA);
      wr(4'h0, 32'h8000_0008);
      chk_sts("R6 ack zeroize on fail", 8'hFA);
      wr(4'h0, 32'h8000_0000);
      chk_sts("R6 enable on fail", 8'hFA);
      ent_valid = 1'b1; ent_data = 32'hDEAD_BEEF;
      idle(1);
      ent_valid = 1'b0;
      chk_dat("R12 data after fail", 32'h0);

      reset_cmd();
      startup(1'b1);
      wr(4'h0, 32'h8000_0000);
      chk_sts("R7 enable before ack", 8'h57);
      chk_dat("R12 data at pass", 32'h0);
      wr(4'h0, 32'h8000_0008);
      chk_sts("R7 run", 8'h00);

      ent_valid = 1'b1; ent_data = 32'hA5A5_0001;
      idle(1);
      chk_sts("R9 no capture unarmed", 8'h00);
      wr(4'h0, 32'h8000_0000);
      chk_sts("R9 enable edge with valid", 8'h00);
      idle(1);
      ent_valid = 1'b0;
      chk_sts("R8 word available", 8'hED);
      chk_dat("R8 word value", 32'hA5A5_0001);
      ent_valid = 1'b1; ent_data = 32'h0BAD_0BAD;
      idle(1);
      ent_valid = 1'b0;
      chk_dat("R9 second valid ignored", 32'hA5A5_0001);
      wr(4'h0, 32'h8000_0000);
      chk_dat("R9 enable while held", 32'hA5A5_0001);
      wr(4'h4, 32'h0000_0001);
      chk_dat("R2 reset at status offset", 32'hA5A5_0001);
      wr(4'h0, 32'h8000_000F);
      chk_sts("R9 read ack", 8'h00);
      chk_dat("R12 data after ack", 32'h0);
      ent_valid = 1'b1; ent_data = 32'h7777_7777;
      idle(2);
      ent_valid = 1'b0;
      chk_sts("R9 no rearm", 8'h00);

      for (int i = 0; i < 40; i++) begin
         w = $urandom();
         wr(4'h0, 32'h8000_0000);
         if ($urandom_range(0, 1) == 1) wr(4'h0, junk_cmd($urandom()));
         idle($urandom_range(0, 3));
         ent_valid = 1'b1; ent_data = w;
         idle(1);
         ent_valid = 1'b0;
         chk_sts("R8 random status", 8'hED);
         chk_dat("R8 random word", exp_data(1'b1, w));
         if ($urandom_range(0, 1) == 1) begin
            wr(4'h0, junk_cmd($urandom()));
            chk_dat("R10 junk while held", exp_data(1'b1, w));
         end
         wr(4'h0, 32'h8000_000F);
         chk_dat("R9 random ack", exp_data(1'b0, w));
      end

      wr(4'h0, 32'h8000_0000);
      ent_valid = 1'b1; ent_data = 32'hCAFE_F00D;
      wr(4'h0, 32'h0000_0001);
      ent_valid = 1'b0;
      chk_sts("R11 reset beats capture", 8'h00);
      chk_dat("R11 reset beats capture data", 32'h0);
      idle(RC);
      chk_sts("R11 reset completes", 8'hAC);

      startup(1'b1);
      wr(4'h0, 32'h8000_0008);
      wr(4'h0, 32'h8000_0000);
      ent_valid = 1'b1; ent_data = 32'h1357_9BDF;
      idle(1);
      ent_valid = 1'b0;
      chk_dat("R8 word before reset", 32'h1357_9BDF);
      wr(4'h0, 32'h0000_0001);
      chk_dat("R11 reset drops word", 32'h0);
      chk_sts("R11 reset status", 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule